// File: doc/BRIEF.md
# Masked Content-Addressable Word Store

This block is a small associative memory. It holds a fixed number of words, and each word has a valid flag. A caller finds words by their content, not by an address. On a search strobe, the block compares an argument word and a per-bit key against every stored word in parallel. A key bit of 1 makes that argument bit take part in the compare. A key bit of 0 makes that position count as equal whatever it holds. The per-word hit bits go into a registered match vector.

A write carries only data. The block stores it in the lowest-numbered slot that is not valid, and it reports a full condition once no such slot is left. After a search, a readout port walks the match vector. It presents one hit word at a time, lowest index first, and advances on a `next` strobe. It raises a done flag once the last hit has been taken. A single clear command invalidates the whole store in one cycle.

Top module: `mcam_top`

## Requirements
- R1: Only argument positions whose key bit is 1 are compared. A key of all zeros makes every valid word a hit.
- R2: With a key of all ones, a word is a hit only when all of its bits equal the argument.
- R3: Match bit i is 1 exactly when word i is valid and every unmasked bit of it equals the argument. A word that is not valid never sets its match bit.
- R4: The match vector takes the search result at the first clock edge after `srch_en` is high. It then holds its value until the next search or clear.
- R5: A write (`wr_en`) with free space stores `wr_data` in the lowest-indexed slot that is not valid. The word is visible to a search issued in the following cycle.
- R6: `full` is 1 exactly when every slot holds a valid word.
- R7: A write issued while `full` is high changes no stored word. `wr_err` is high for the one cycle after each such write.
- R8: After a search with hits, `rd_valid` is 1 and `rd_index`/`rd_data` show the lowest remaining hit. Each `rd_next` while `rd_valid` moves to the next higher hit.
- R9: `rd_done` is 1, with `rd_valid` 0, once a search has no hits left to read: either it found none, or its last hit has been stepped past.
- R10: `clr_all` invalidates every slot and zeroes the match vector in one cycle. It also returns the readout to idle, where `rd_valid` and `rd_done` are both 0.
- R11: After reset, `full`, `wr_err`, `match_vec`, `rd_valid` and `rd_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_all | input | 1 | Invalidate every slot and clear search state |
| wr_en | input | 1 | Store `wr_data` in the first free slot |
| wr_data | input | WIDTH | Word to store |
| srch_en | input | 1 | Search strobe |
| srch_arg | input | WIDTH | Argument word for the search |
| srch_key | input | WIDTH | Per-bit compare enable (1 = compare) |
| rd_next | input | 1 | Take the current hit and advance |
| rd_valid | output | 1 | A hit is presented on `rd_index`/`rd_data` |
| rd_index | output | IDXW | Slot index of the presented hit |
| rd_data | output | WIDTH | Stored word of the presented hit |
| rd_done | output | 1 | Search finished with no hits left to read |
| match_vec | output | WORDS | Registered per-word match result |
| full | output | 1 | No free slot remains |
| wr_err | output | 1 | One-cycle pulse after a dropped write |

## Verification
Every result here is due one clock edge after the strobe that causes it. Searches, writes, dropped writes, clears and readout steps all follow this rule: `match_vec`, `full`, `wr_err` and the readout outputs change at the first rising edge after the input was seen high. The bench drives each strobe on a falling edge, holds it for one full cycle and samples on the next falling edge. Each sample therefore lands half a cycle after the edge that must have produced the result. The bench then takes further samples one cycle later to confirm that pulses have ended and that held values remain stable.

// File: rtl/mcam_pkg.sv
package mcam_pkg;

    localparam int MCAM_WORDS_DEF = 8;
    localparam int MCAM_WIDTH_DEF = 16;

    // Readout walker phases
    typedef enum logic [1:0] {
        RO_IDLE = 2'd0,   // no search since reset or clear
        RO_WALK = 2'd1,   // hits remain to be read
        RO_DONE = 2'd2    // search finished, nothing left
    } ro_state_e;

    // One bit position takes part only if its key bit is set
    function automatic logic masked_bit_eq(input logic w, input logic a, input logic k);
        return (~k) | (w ~^ a);
    endfunction

endpackage

// File: rtl/mcam_free_finder.sv
module mcam_free_finder #(
    parameter int WORDS = mcam_pkg::MCAM_WORDS_DEF,
    parameter int IDXW  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic [WORDS-1:0] valid,
    output logic [IDXW-1:0]  free_idx,
    output logic             full
);
    always_comb begin
        free_idx = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDXW'(i);
        end
    end

    assign full = &valid;
endmodule

// File: rtl/mcam_match_array.sv
module mcam_match_array
    import mcam_pkg::*;
#(
    parameter int WORDS = MCAM_WORDS_DEF,
    parameter int WIDTH = MCAM_WIDTH_DEF
) (
    input  logic [WIDTH-1:0] words [WORDS],
    input  logic [WORDS-1:0] valid,
    input  logic [WIDTH-1:0] arg,
    input  logic [WIDTH-1:0] key,
    output logic [WORDS-1:0] hits
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [WIDTH-1:0] eq_bits;
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            assign eq_bits[b] = masked_bit_eq(words[w][b], arg[b], key[b]);
        end
        assign hits[w] = valid[w] & (&eq_bits);
    end
endmodule

// File: rtl/mcam_readout.sv
module mcam_readout
    import mcam_pkg::*;
#(
    parameter int WORDS = MCAM_WORDS_DEF,
    parameter int IDXW  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [WORDS-1:0] load_vec,
    input  logic             step,
    output logic [IDXW-1:0]  sel_idx,
    output logic             walking,
    output logic             done
);
    ro_state_e        state_q;
    logic [WORDS-1:0] pend_q;
    logic [WORDS-1:0] sel_onehot;

    always_comb begin
        sel_idx = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (pend_q[i]) sel_idx = IDXW'(i);
        end
        sel_onehot = '0;
        sel_onehot[sel_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state_q <= RO_IDLE;
            pend_q  <= '0;
        end else if (load) begin
            pend_q  <= load_vec;
            state_q <= (load_vec != '0) ? RO_WALK : RO_DONE;
        end else if (step && state_q == RO_WALK) begin
            pend_q <= pend_q & ~sel_onehot;
            if ((pend_q & ~sel_onehot) == '0) state_q <= RO_DONE;
        end
    end

    assign walking = (state_q == RO_WALK);
    assign done    = (state_q == RO_DONE);

    AST_WALK_HAS_PENDING: assert property (@(posedge clk) disable iff (rst)
        walking |-> (pend_q != '0)); // R8
    AST_DONE_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
        done |-> (!walking && pend_q == '0)); // R9
    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (walking && step && !load && !clr) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1)); // R8
endmodule

// File: rtl/mcam_top.sv
module mcam_top
    import mcam_pkg::*;
#(
    parameter int WORDS = MCAM_WORDS_DEF,
    parameter int WIDTH = MCAM_WIDTH_DEF,
    localparam int IDXW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_all,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             srch_en,
    input  logic [WIDTH-1:0] srch_arg,
    input  logic [WIDTH-1:0] srch_key,
    input  logic             rd_next,
    output logic             rd_valid,
    output logic [IDXW-1:0]  rd_index,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_done,
    output logic [WORDS-1:0] match_vec,
    output logic             full,
    output logic             wr_err
);
    logic [WIDTH-1:0] mem_q [WORDS];
    logic [WORDS-1:0] valid_q;
    logic [WORDS-1:0] match_q;
    logic [WORDS-1:0] hits_w;
    logic [IDXW-1:0]  free_idx;
    logic             full_w;
    logic             wr_err_q;
    logic             wr_ok;

    mcam_free_finder #(.WORDS(WORDS), .IDXW(IDXW)) u_free (
        .valid    (valid_q),
        .free_idx (free_idx),
        .full     (full_w)
    );

    mcam_match_array #(.WORDS(WORDS), .WIDTH(WIDTH)) u_cmp (
        .words (mem_q),
        .valid (valid_q),
        .arg   (srch_arg),
        .key   (srch_key),
        .hits  (hits_w)
    );

    assign wr_ok = wr_en && !full_w && !clr_all;

    always_ff @(posedge clk) begin
        if (wr_ok) mem_q[free_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            valid_q  <= '0;
            match_q  <= '0;
            wr_err_q <= 1'b0;
        end else begin
            wr_err_q <= wr_en && full_w;
            if (wr_ok) valid_q[free_idx] <= 1'b1;
            if (srch_en) match_q <= hits_w;
        end
    end

    mcam_readout #(.WORDS(WORDS), .IDXW(IDXW)) u_ro (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr_all),
        .load     (srch_en),
        .load_vec (hits_w),
        .step     (rd_next),
        .sel_idx  (rd_index),
        .walking  (rd_valid),
        .done     (rd_done)
    );

    assign rd_data   = rd_valid ? mem_q[rd_index] : '0;
    assign match_vec = match_q;
    assign full      = full_w;
    assign wr_err    = wr_err_q;

    AST_MATCH_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
        (match_q & ~valid_q) == '0); // R3
    AST_MATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!srch_en && !clr_all) |=> $stable(match_q)); // R4
    AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (full_w && wr_en && !clr_all) |=> ($stable(valid_q) && wr_err_q)); // R7
    AST_ERR_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        wr_err_q |-> $past(full_w && wr_en)); // R7
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (valid_q == '0 && match_q == '0 && !rd_valid && !rd_done)); // R10
    AST_WRITE_FILLS_ONE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !full_w && !clr_all) |=> ($countones(valid_q) == $countones($past(valid_q)) + 1)); // R5
endmodule

// File: tb/mcam_top_test.sv
`timescale 1ns/1ps
module mcam_top_test;
    localparam int WORDS = 8;
    localparam int WIDTH = 16;
    localparam int IDXW  = 3;
    localparam int NSRCH = 9;

    // {arg[15:0], key[15:0], expected match[7:0]}
    localparam logic [39:0] SRCH_TBL [NSRCH] = '{
        {16'h1234, 16'hFFFF, 8'h81},  // R2 exact
        {16'h1234, 16'hFFF0, 8'h83},  // R1 low nibble ignored
        {16'h0234, 16'h0FFF, 8'h85},  // R1 top nibble ignored
        {16'h0000, 16'h0000, 8'hFF},  // R1 no bits compared
        {16'hF0F4, 16'h00FF, 8'h20},  // R1 low byte only
        {16'hFFFF, 16'hFFFF, 8'h10},  // R2
        {16'h0000, 16'hF000, 8'h08},  // R3
        {16'h5678, 16'hFFFF, 8'h40},  // R2
        {16'h1234, 16'hFF00, 8'hA3}   // R1 top byte only
    };
    localparam logic [15:0] FILL [WORDS] = '{
        16'h1234, 16'h1235, 16'hA234, 16'h0000,
        16'hFFFF, 16'h12F4, 16'h5678, 16'h1234
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             clr_all = 1'b0;
    logic             wr_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             srch_en = 1'b0;
    logic [WIDTH-1:0] srch_arg = '0;
    logic [WIDTH-1:0] srch_key = '0;
    logic             rd_next = 1'b0;
    logic             rd_valid;
    logic [IDXW-1:0]  rd_index;
    logic [WIDTH-1:0] rd_data;
    logic             rd_done;
    logic [WORDS-1:0] match_vec;
    logic             full;
    logic             wr_err;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    mcam_top #(.WORDS(WORDS), .WIDTH(WIDTH)) uut (
        .clk(clk), .rst(rst), .clr_all(clr_all),
        .wr_en(wr_en), .wr_data(wr_data),
        .srch_en(srch_en), .srch_arg(srch_arg), .srch_key(srch_key),
        .rd_next(rd_next), .rd_valid(rd_valid), .rd_index(rd_index),
        .rd_data(rd_data), .rd_done(rd_done), .match_vec(match_vec),
        .full(full), .wr_err(wr_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [WIDTH-1:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_search(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] k);
        @(negedge clk); srch_en = 1'b1; srch_arg = a; srch_key = k;
        @(negedge clk); srch_en = 1'b0;
    endtask

    task automatic do_step();
        @(negedge clk); rd_next = 1'b1;
        @(negedge clk); rd_next = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk); clr_all = 1'b1;
        @(negedge clk); clr_all = 1'b0;
    endtask

    task automatic expect_hit(input string req, input int idx, input logic [WIDTH-1:0] d);
        check(req, {31'd0, rd_valid}, 32'd1);
        check(req, {29'd0, rd_index}, idx);
        check(req, {16'd0, rd_data}, {16'd0, d});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 full", {31'd0, full}, 0);
        check("R11 wr_err", {31'd0, wr_err}, 0);
        check("R11 match", {24'd0, match_vec}, 0);
        check("R11 rd_valid", {31'd0, rd_valid}, 0);
        check("R11 rd_done", {31'd0, rd_done}, 0);

        // R5/R6 fill the store, full only after the last slot
        for (int i = 0; i < WORDS; i++) begin
            do_write(FILL[i]);
            check("R6 full while filling", {31'd0, full}, (i == WORDS - 1) ? 1 : 0);
            check("R7 no error on free write", {31'd0, wr_err}, 0);
        end

        // R7 dropped write: one-cycle error pulse, nothing stored
        do_write(16'hBEEF);
        check("R7 wr_err pulse", {31'd0, wr_err}, 1);
        @(negedge clk);
        check("R7 wr_err ends", {31'd0, wr_err}, 0);
        do_search(16'hBEEF, 16'hFFFF);
        check("R7 dropped word absent", {24'd0, match_vec}, 0);
        check("R9 done on no hits", {30'd0, rd_done, rd_valid}, 32'd2);
        check("R6 still full", {31'd0, full}, 1);

        // R1/R2/R3 table of masked searches
        for (int t = 0; t < NSRCH; t++) begin
            do_search(SRCH_TBL[t][39:24], SRCH_TBL[t][23:8]);
            check("R1 R2 R3 match table", {24'd0, match_vec}, {24'd0, SRCH_TBL[t][7:0]});
        end

        // R4 held without a strobe
        repeat (2) @(negedge clk);
        check("R4 match held", {24'd0, match_vec}, 32'hA3);

        // R8/R9 readout of hits 0,1,5,7 from the last search
        expect_hit("R8 first hit", 0, 16'h1234);
        do_step();
        expect_hit("R8 second hit", 1, 16'h1235);
        do_step();
        expect_hit("R8 third hit", 5, 16'h12F4);
        do_step();
        expect_hit("R8 fourth hit", 7, 16'h1234);
        check("R9 not done yet", {31'd0, rd_done}, 0);
        do_step();
        check("R9 done after last", {30'd0, rd_done, rd_valid}, 32'd2);
        check("R4 match unchanged by readout", {24'd0, match_vec}, 32'hA3);

        // R4 search result due one edge after strobe
        @(negedge clk); srch_en = 1'b1; srch_arg = 16'h5678; srch_key = 16'hFFFF;
        check("R4 not before edge", {24'd0, match_vec}, 32'hA3);
        @(negedge clk); srch_en = 1'b0;
        check("R4 after edge", {24'd0, match_vec}, 32'h40);

        // R10 clear-all
        do_clear();
        check("R10 full cleared", {31'd0, full}, 0);
        check("R10 match cleared", {24'd0, match_vec}, 0);
        check("R10 readout idle", {30'd0, rd_done, rd_valid}, 0);
        do_search(16'h0000, 16'h0000);
        check("R3 invalid words never hit", {24'd0, match_vec}, 0);

        // R5 slots refill from index 0
        do_write(16'hCAFE);
        do_write(16'hCAFF);
        do_search(16'hCAF0, 16'hFFF0);
        check("R5 refill order", {24'd0, match_vec}, 32'h03);
        expect_hit("R5 first slot", 0, 16'hCAFE);
        do_step();
        expect_hit("R5 second slot", 1, 16'hCAFF);

        // R5 write visible to search in the next cycle
        @(negedge clk); wr_en = 1'b1; wr_data = 16'h7777;
        @(negedge clk); wr_en = 1'b0; srch_en = 1'b1; srch_arg = 16'h7777; srch_key = 16'hFFFF;
        @(negedge clk); srch_en = 1'b0;
        check("R5 next-cycle visibility", {24'd0, match_vec}, 32'h04);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule